// File: doc/BRIEF.md
# Exception Entry Priority Controller

This block owns the current program status word of a 32-bit core, together with one saved copy for each privileged mode. Each cycle it looks at seven exception request lines. These are reset, data abort, fast interrupt, interrupt, prefetch abort, undefined instruction and software interrupt. The interrupt lines are first gated by the two disable bits of the status word. The controller then picks the most urgent request that remains. In a single clock edge it writes the new status word, files the old one in the saved-status slot of the target mode, and emits an entry record. The record carries the exception kind, the target mode, the vector address, the return-link value and the saved status.

The core drives three address-related inputs. `cur_pc` is the address of the faulting instruction. `next_pc` is the address of the next instruction to run, which is also the instruction after a trapping one. `hivec` selects the low or the high vector base. Handler code leaves an exception with a return strobe, which reloads the status word from the saved copy of the current mode. Software can also load the status word directly through a write port.

The entry record leaves through a valid/ready interface. When `ent_valid` is high and `ent_ready` is low, the record is held unchanged and no further exception is taken. Requests stay pending at the inputs until the slot frees. A new entry may be taken in the same cycle that the pending record is accepted.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Request bit positions and kind codes are equal: 0 reset, 1 data abort, 2 fast interrupt, 3 interrupt, 4 prefetch abort, 5 undefined, 6 software interrupt. The lowest-numbered enabled request wins, so undefined beats software interrupt when both are present.
- R2: On entry, status bits 4:0 take the target mode and bit 5 is cleared, while bits 31:8 are kept. Reset and software interrupt enter 5'b10011, both aborts enter 5'b10111, fast interrupt enters 5'b10001, interrupt enters 5'b10010 and undefined enters 5'b11011. `ent_mode` reports the target mode.
- R3: Every entry sets status bit 7. Bit 6 is set on reset and fast-interrupt entry, and keeps its old value on every other entry.
- R4: An interrupt request is ignored while status bit 7 is set. A fast-interrupt request is ignored while status bit 6 is set.
- R5: `ent_vector` is the base plus an offset. The base is 0, or 0xFFFF0000 when `hivec` is 1. The offsets are: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, interrupt 0x18, fast interrupt 0x1C.
- R6: `ent_link` is `cur_pc`+8 for a data abort and `cur_pc`+4 for a prefetch abort. It is `next_pc`+4 for interrupt and fast interrupt, and `next_pc` for undefined and software interrupt. It is unspecified for reset.
- R7: `ent_saved` equals the status word held before the entry, and that value is stored in the saved slot of the target mode. On reset entry, `ent_saved` is unspecified and no slot is written.
- R8: A `ret_stb` pulse copies the saved slot of the current mode into the status word. It is ignored in modes 5'b10000 and 5'b11111. An entry in the same cycle takes precedence over the return.
- R9: A `psr_wr` pulse loads `psr_wdata` into the status word when neither an entry nor an accepted return happens in that cycle.
- R10: While `ent_valid` is high and `ent_ready` is low, the record stays stable and no request is taken.
- R11: After `rst_n` is released, `psr` is 0x000000D3, `ent_valid` is 0 and all saved slots are 0.
- R12: With no enabled request, no entry is made and `ent_valid` falls once the record is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_req | input | 7 | Exception request lines, bit order as R1 |
| cur_pc | input | AW | Address of the faulting instruction |
| next_pc | input | AW | Address of the next or following instruction |
| hivec | input | 1 | Selects the high vector base |
| ret_stb | input | 1 | Return from exception: restore saved status |
| psr_wr | input | 1 | Direct status-word write strobe |
| psr_wdata | input | 32 | Data for the direct status write |
| ent_ready | input | 1 | Consumer accepts the entry record |
| ent_valid | output | 1 | Entry record present |
| ent_kind | output | 3 | Kind code of the taken exception |
| ent_mode | output | 5 | Target mode |
| ent_vector | output | AW | Vector address |
| ent_link | output | AW | Return-link value |
| ent_saved | output | 32 | Status word before the entry |
| psr | output | 32 | Current status word |

## Verification
A directed phase checks five things. First, it shows that an interrupt arriving with bit 7 set causes no entry, which separates masking from arbitration. Second, it raises all seven lines at once and then removes the winner one by one, which exposes the full priority chain, including the tie-break between undefined and software interrupt. Third, it holds `ent_ready` low while requests keep arriving, which separates back-pressure from idle. Fourth, it issues returns from a privileged mode and from user mode, which shows whether the correct saved slot is used. Fifth, it makes entries with different disable bits, which tells whether bit 6 is set selectively or on every entry. A random phase then mixes sparse requests, status writes with random mode and mask bits, returns, a toggling `hivec` and random ready, so that entry, return and write collide in the same cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NUM_EXC = 7;
  localparam int NUM_BANK = 5;
  localparam int PSR_W = 32;

  typedef enum logic [2:0] {
    EK_RESET = 3'd0,
    EK_DABT  = 3'd1,
    EK_FIQ   = 3'd2,
    EK_IRQ   = 3'd3,
    EK_PABT  = 3'd4,
    EK_UND   = 3'd5,
    EK_SWI   = 3'd6
  } exc_kind_e;

  localparam logic [4:0] MD_USR = 5'b10000;
  localparam logic [4:0] MD_FIQ = 5'b10001;
  localparam logic [4:0] MD_IRQ = 5'b10010;
  localparam logic [4:0] MD_SVC = 5'b10011;
  localparam logic [4:0] MD_ABT = 5'b10111;
  localparam logic [4:0] MD_UND = 5'b11011;
  localparam logic [4:0] MD_SYS = 5'b11111;

  localparam int BIT_T = 5;
  localparam int BIT_F = 6;
  localparam int BIT_I = 7;

  localparam logic [PSR_W-1:0] PSR_RESET = 32'h0000_00D3;

  // Saved-slot index for a mode; bank_ok false for modes without a slot.
  function automatic logic [2:0] bank_idx(input logic [4:0] md);
    case (md)
      MD_FIQ:  bank_idx = 3'd0;
      MD_IRQ:  bank_idx = 3'd1;
      MD_SVC:  bank_idx = 3'd2;
      MD_ABT:  bank_idx = 3'd3;
      MD_UND:  bank_idx = 3'd4;
      default: bank_idx = 3'd7;
    endcase
  endfunction

  function automatic logic bank_ok(input logic [4:0] md);
    bank_ok = (bank_idx(md) != 3'd7);
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int N = NUM_EXC
) (
  input  logic [N-1:0]     req,
  input  logic [PSR_W-1:0] psr_cur,
  output logic             any,
  output exc_kind_e        kind
);
  logic [N-1:0] enabled;

  // Interrupt lines are gated by their disable bits.
  generate
    for (genvar g = 0; g < N; g++) begin : g_mask
      if (g == int'(EK_FIQ)) begin : g_f
        assign enabled[g] = req[g] & ~psr_cur[BIT_F];
      end else if (g == int'(EK_IRQ)) begin : g_i
        assign enabled[g] = req[g] & ~psr_cur[BIT_I];
      end else begin : g_p
        assign enabled[g] = req[g];
      end
    end
  endgenerate

  always_comb begin
    kind = EK_RESET;
    for (int i = N - 1; i >= 0; i--) begin
      if (enabled[i]) kind = exc_kind_e'(i[2:0]);
    end
  end

  assign any = |enabled;
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  exc_kind_e        kind,
  input  logic [PSR_W-1:0] psr_old,
  input  logic [AW-1:0]    cur_pc,
  input  logic [AW-1:0]    next_pc,
  input  logic             hivec,
  output logic [PSR_W-1:0] psr_new,
  output logic [4:0]       mode,
  output logic [AW-1:0]    vector,
  output logic [AW-1:0]    link
);
  localparam int OFF_W = 5;
  logic [OFF_W-1:0] off;
  logic             set_f;

  always_comb begin
    mode  = MD_SVC;
    off   = '0;
    link  = '0;
    set_f = 1'b0;
    case (kind)
      EK_RESET: begin mode = MD_SVC; off = 5'h00; set_f = 1'b1; end
      EK_DABT:  begin mode = MD_ABT; off = 5'h10; link = cur_pc + AW'(8); end
      EK_FIQ:   begin mode = MD_FIQ; off = 5'h1C; link = next_pc + AW'(4); set_f = 1'b1; end
      EK_IRQ:   begin mode = MD_IRQ; off = 5'h18; link = next_pc + AW'(4); end
      EK_PABT:  begin mode = MD_ABT; off = 5'h0C; link = cur_pc + AW'(4); end
      EK_UND:   begin mode = MD_UND; off = 5'h04; link = next_pc; end
      EK_SWI:   begin mode = MD_SVC; off = 5'h08; link = next_pc; end
      default:  begin mode = MD_SVC; off = 5'h00; end
    endcase
  end

  assign vector = (hivec ? HI_BASE : '0) | AW'(off);

  always_comb begin
    psr_new = psr_old;
    psr_new[4:0]   = mode;
    psr_new[BIT_T] = 1'b0;
    psr_new[BIT_I] = 1'b1;
    if (set_f) psr_new[BIT_F] = 1'b1;
  end
endmodule

// File: rtl/psr_bank.sv
module psr_bank
  import exc_pkg::*;
#(
  parameter int W  = PSR_W,
  parameter int NB = NUM_BANK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_idx,
  input  logic [W-1:0] wr_data,
  input  logic [2:0]   rd_idx,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] slot [NB];

  generate
    for (genvar b = 0; b < NB; b++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot[b] <= '0;
        else if (wr_en && wr_idx == 3'(b)) slot[b] <= wr_data;
      end
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < NB; b++) begin
      if (rd_idx == 3'(b)) rd_data = slot[b];
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [6:0]       exc_req,
  input  logic [AW-1:0]    cur_pc,
  input  logic [AW-1:0]    next_pc,
  input  logic             hivec,
  input  logic             ret_stb,
  input  logic             psr_wr,
  input  logic [31:0]      psr_wdata,
  input  logic             ent_ready,
  output logic             ent_valid,
  output logic [2:0]       ent_kind,
  output logic [4:0]       ent_mode,
  output logic [AW-1:0]    ent_vector,
  output logic [AW-1:0]    ent_link,
  output logic [31:0]      ent_saved,
  output logic [31:0]      psr
);
  logic             any;
  exc_kind_e        kind;
  logic [PSR_W-1:0] psr_new;
  logic [4:0]       tgt_mode;
  logic [AW-1:0]    vec;
  logic [AW-1:0]    lnk;
  logic [PSR_W-1:0] saved_rd;
  logic             take;
  logic             ret_ok;
  logic             bank_wr;

  exc_arbiter #(.N(NUM_EXC)) u_arb (
    .req(exc_req), .psr_cur(psr), .any(any), .kind(kind)
  );

  exc_entry_calc #(.AW(AW), .HI_BASE(HI_BASE)) u_calc (
    .kind(kind), .psr_old(psr), .cur_pc(cur_pc), .next_pc(next_pc),
    .hivec(hivec), .psr_new(psr_new), .mode(tgt_mode), .vector(vec), .link(lnk)
  );

  assign take    = any && (!ent_valid || ent_ready);
  assign bank_wr = take && (kind != EK_RESET);
  assign ret_ok  = ret_stb && bank_ok(psr[4:0]);

  psr_bank #(.W(PSR_W), .NB(NUM_BANK)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bank_wr), .wr_idx(bank_idx(tgt_mode)), .wr_data(psr),
    .rd_idx(bank_idx(psr[4:0])), .rd_data(saved_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      psr <= PSR_RESET;
    else if (take)   psr <= psr_new;
    else if (ret_ok) psr <= saved_rd;
    else if (psr_wr) psr <= psr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid  <= 1'b0;
      ent_kind   <= '0;
      ent_mode   <= '0;
      ent_vector <= '0;
      ent_link   <= '0;
      ent_saved  <= '0;
    end else if (take) begin
      ent_valid  <= 1'b1;
      ent_kind   <= kind;
      ent_mode   <= tgt_mode;
      ent_vector <= vec;
      ent_link   <= lnk;
      ent_saved  <= psr;
    end else if (ent_ready) begin
      ent_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk #(
  parameter int AW = 32,
  parameter logic [AW-1:0] HI_BASE = 32'hFFFF_0000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hivec,
  input logic [31:0]   psr,
  input logic          ent_valid,
  input logic          ent_ready,
  input logic [2:0]    ent_kind,
  input logic [4:0]    ent_mode,
  input logic [AW-1:0] ent_vector,
  input logic [AW-1:0] ent_link
);
  logic prev_v, prev_r, fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_v <= 1'b0;
      prev_r <= 1'b0;
    end else begin
      prev_v <= ent_valid;
      prev_r <= ent_ready;
    end
  end

  assign fresh = ent_valid && !(prev_v && !prev_r);

  a_r2_mode_and_state: assert property (@(posedge clk) disable iff (!rst_n)
    fresh |-> (psr[4:0] == ent_mode) && !psr[5]);

  a_r3_irq_disable: assert property (@(posedge clk) disable iff (!rst_n)
    fresh |-> psr[7]);

  a_r3_fiq_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh && (ent_kind == 3'd0 || ent_kind == 3'd2)) |-> psr[6]);

  a_r4_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh && ent_kind == 3'd3) |-> !$past(psr[7]));

  a_r4_fiq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh && ent_kind == 3'd2) |-> !$past(psr[6]));

  a_r5_vector_base: assert property (@(posedge clk) disable iff (!rst_n)
    fresh |-> ((ent_vector & ~AW'(31)) == ($past(hivec) ? HI_BASE : '0)));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && !ent_ready) |=> ent_valid && $stable(ent_kind) &&
      $stable(ent_vector) && $stable(ent_link) && $stable(ent_mode));
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.AW(AW), .HI_BASE(HI_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .hivec(hivec), .psr(psr),
  .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_kind(ent_kind),
  .ent_mode(ent_mode), .ent_vector(ent_vector), .ent_link(ent_link)
);

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  exc_req = '0;
  logic [31:0] cur_pc = '0, next_pc = '0;
  logic        hivec = 1'b0, ret_stb = 1'b0, psr_wr = 1'b0, ent_ready = 1'b1;
  logic [31:0] psr_wdata = '0;
  logic        ent_valid;
  logic [2:0]  ent_kind;
  logic [4:0]  ent_mode;
  logic [31:0] ent_vector, ent_link, ent_saved, psr;

  int vectors = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  exc_entry_ctrl i_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .cur_pc(cur_pc),
    .next_pc(next_pc), .hivec(hivec), .ret_stb(ret_stb), .psr_wr(psr_wr),
    .psr_wdata(psr_wdata), .ent_ready(ent_ready), .ent_valid(ent_valid),
    .ent_kind(ent_kind), .ent_mode(ent_mode), .ent_vector(ent_vector),
    .ent_link(ent_link), .ent_saved(ent_saved), .psr(psr)
  );

  // Behavioural reference model
  logic [31:0] m_psr, m_vec, m_link, m_saved;
  logic [31:0] m_slot [5];
  logic        m_valid;
  logic [2:0]  m_kind;
  logic [4:0]  m_mode;

  function automatic int slot_of(input logic [4:0] md);
    case (md)
      5'b10001: return 0;
      5'b10010: return 1;
      5'b10011: return 2;
      5'b10111: return 3;
      5'b11011: return 4;
      default:  return -1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int win;
    logic [4:0] md;
    logic [31:0] off, lk, np;
    if (!rst_n) begin
      m_psr <= 32'hD3; m_valid <= 0; m_kind <= 0; m_mode <= 0;
      m_vec <= 0; m_link <= 0; m_saved <= 0;
      for (int b = 0; b < 5; b++) m_slot[b] <= 0;
    end else begin
      win = -1;
      for (int i = 6; i >= 0; i--) begin
        if (exc_req[i] && !(i == 2 && m_psr[6]) && !(i == 3 && m_psr[7])) win = i;
      end
      if (win >= 0 && (!m_valid || ent_ready)) begin
        np = m_psr; lk = 0;
        case (win)
          0: begin md = 5'b10011; off = 32'h00; np[6] = 1; end
          1: begin md = 5'b10111; off = 32'h10; lk = cur_pc + 8; end
          2: begin md = 5'b10001; off = 32'h1C; lk = next_pc + 4; np[6] = 1; end
          3: begin md = 5'b10010; off = 32'h18; lk = next_pc + 4; end
          4: begin md = 5'b10111; off = 32'h0C; lk = cur_pc + 4; end
          5: begin md = 5'b11011; off = 32'h04; lk = next_pc; end
          default: begin md = 5'b10011; off = 32'h08; lk = next_pc; end
        endcase
        np[7] = 1; np[5] = 0; np[4:0] = md;
        if (win != 0) m_slot[slot_of(md)] <= m_psr;
        m_psr <= np; m_valid <= 1; m_kind <= 3'(win); m_mode <= md;
        m_vec <= (hivec ? 32'hFFFF0000 : 32'h0) + off;
        m_link <= lk; m_saved <= m_psr;
      end else begin
        if (ent_ready) m_valid <= 0;
        if (ret_stb && slot_of(m_psr[4:0]) >= 0) m_psr <= m_slot[slot_of(m_psr[4:0])];
        else if (psr_wr) m_psr <= psr_wdata;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    vectors++;
    chk("R4/R10/R12 ent_valid", 32'(ent_valid), 32'(m_valid));
    chk("R2/R3/R8/R9/R11 psr", psr, m_psr);
    if (m_valid) begin
      chk("R1 ent_kind", 32'(ent_kind), 32'(m_kind));
      chk("R2 ent_mode", 32'(ent_mode), 32'(m_mode));
      chk("R5 ent_vector", ent_vector, m_vec);
      if (m_kind != 0) begin
        chk("R6 ent_link", ent_link, m_link);
        chk("R7 ent_saved", ent_saved, m_saved);
      end
    end
  endtask

  // One cycle: compare at the falling edge, then drive the next inputs.
  task automatic step(input logic [6:0] rq, input logic rdy, input logic ret,
                      input logic wr, input logic [31:0] wd);
    @(negedge clk);
    compare();
    exc_req = rq; ent_ready = rdy; ret_stb = ret; psr_wr = wr; psr_wdata = wd;
    cur_pc = $urandom & 32'hFFFF_FFFC; next_pc = $urandom & 32'hFFFF_FFFC;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R11: reset state, then R4: IRQ ignored while I set
    step(7'b0001000, 1, 0, 0, 0);
    step(7'b0001000, 1, 0, 0, 0);
    step(7'b0000100, 1, 0, 0, 0);
    // R9: write user mode with interrupts enabled
    step(7'b0, 1, 0, 1, 32'hF000_0010);
    step(7'b0001000, 1, 0, 0, 0);   // IRQ entry
    step(7'b0, 1, 0, 0, 0);
    step(7'b0, 1, 1, 0, 0);          // R8 return to user
    step(7'b0, 1, 1, 0, 0);          // R8 return ignored in user mode
    step(7'b0000100, 1, 0, 0, 0);    // FIQ entry (R3 F set)
    step(7'b0, 1, 1, 0, 0);
    // R1 priority chain with all lines raised, each winner removed
    for (int k = 0; k < 7; k++) begin
      step(7'b0, 1, 0, 1, 32'h0000_0010);
      step(7'h7F << k, 1, 0, 0, 0);
    end
    step(7'b0, 1, 0, 1, 32'h0000_0010);
    step(7'b1100000, 1, 0, 0, 0);    // R1 undefined beats software interrupt
    // R10 back-pressure
    hivec = 1;
    step(7'b0, 1, 0, 1, 32'h0000_0010);
    step(7'b0000010, 0, 0, 0, 0);
    step(7'b0010000, 0, 0, 0, 0);
    step(7'b0010000, 0, 0, 0, 0);
    step(7'b0010000, 1, 0, 0, 0);
    step(7'b0, 1, 0, 0, 0);
    step(7'b0, 1, 0, 0, 0);          // R12 idle
    // Random phase
    for (int n = 0; n < 4000; n++) begin
      logic [6:0] rq;
      logic [31:0] wd;
      logic [4:0] mds [7];
      mds = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111};
      rq = '0;
      for (int b = 0; b < 7; b++) if (($urandom % (b == 0 ? 40 : 9)) == 0) rq[b] = 1;
      wd = $urandom;
      wd[4:0] = mds[$urandom % 7];
      if (($urandom % 16) == 0) hivec = ~hivec;
      step(rq, ($urandom % 4) != 0, ($urandom % 6) == 0, ($urandom % 5) == 0, wd);
    end
    @(negedge clk);
    compare();
    finish_run();
  end
endmodule